// File: doc/BRIEF.md
# Modem Lead Status and Status-Interrupt Unit

This unit watches the four asynchronous leads that a synchronous-line modem presents (carrier detect, data-set-ready, clear-to-send and ring) and turns them into a 16-bit status word for the transmitter side of a line interface. Each lead passes through a flop synchronizer. The data-set-ready, carrier and clear-to-send levels are shown live. A carrier loss (on-to-off only) and a ring indication are caught as sticky event flags. A receiver overrun pulse from the receive datapath is also held as a sticky flag.

Software writes three control bits: terminal-ready, a spare miscellaneous modem output, and a status-interrupt enable. Terminal-ready decides whether the data set is connected to the line. The unit raises a level interrupt request while the enable is set and any event flag is held. Any write or read strobe on the status register clears the event flags. An event that arrives in the same cycle as the clear still lands.

Top module: `mstat_unit`

## Requirements
- R1: While and after a synchronous reset, with every lead low, the status word is 0, `term_ready_o`, `misc_xmt_o` and `stat_irq_o` are 0, and no flag is set.
- R2: Status bits 12 (data-set-ready), 11 (carrier) and 10 (clear-to-send) show the lead level as sampled two clock edges earlier. They are not latched and follow the lead both up and down.
- R3: Status bit 15 is set three edges after the carrier lead goes from 1 to 0. A 0-to-1 change of carrier never sets it.
- R4: Status bit 13 is set three edges after the ring lead goes from 0 to 1.
- R5: Status bit 14 is set on the edge that samples `overrun_evt` high.
- R6: Bits 15, 14 and 13 stay set until an edge samples `sw_wr` or `sw_rd` high. That edge clears all three.
- R7: On a clearing edge, a flag whose event is also due on that edge is left set.
- R8: `stat_irq_o` is high exactly when the enable (control bit 5) is 1 and at least one of bits 15, 14 or 13 is 1.
- R9: An edge with `sw_wr` high stores `sw_wdata` bit 0 (terminal-ready), bit 2 (miscellaneous output) and bit 5 (status-interrupt enable). Each stored bit drives its output and reads back at the same position in the status word. All other written bits are ignored and leave the status word unchanged.
- R10: Status bit 9 equals `rts_in` in the same cycle. Bits 8 to 6, 4, 3 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 1 | Asynchronous carrier-detect lead |
| dsr_in | input | 1 | Asynchronous data-set-ready lead |
| cts_in | input | 1 | Asynchronous clear-to-send lead |
| ring_in | input | 1 | Asynchronous ring-indicate lead |
| overrun_evt | input | 1 | One-cycle overrun pulse from the receive side |
| rts_in | input | 1 | Request-to-send state from the transmit side |
| sw_wr | input | 1 | Status register write strobe |
| sw_rd | input | 1 | Status register read strobe |
| sw_wdata | input | 16 | Write data |
| status_word | output | 16 | Packed status and control readback |
| term_ready_o | output | 1 | Terminal-ready output to the data set |
| misc_xmt_o | output | 1 | Miscellaneous modem control output |
| stat_irq_o | output | 1 | Level status-interrupt request |

## Verification
The due times differ by path. Live lead bits are due two edges after a lead change, and the carrier-loss and ring flags three edges after. The overrun flag, the control bits and the interrupt are due one edge after their strobe. Bit 9 is due in the same cycle. The bench keeps a history queue per lead and a behavioural model that advances once per rising edge. It compares every field on the following falling edge, so each result is read only once all its register stages have settled. Directed checks on reset, clearing and same-edge collisions sit at those same falling-edge points.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int STAT_W  = 16;
    localparam int N_LEADS = 4;
    localparam int N_EVT   = 3;

    // lead vector positions
    localparam int LD_CAR  = 0;
    localparam int LD_DSR  = 1;
    localparam int LD_CTS  = 2;
    localparam int LD_RING = 3;

    // status word layout
    localparam int B_CARF  = 15;
    localparam int B_OVRF  = 14;
    localparam int B_RINGF = 13;
    localparam int B_DSR   = 12;
    localparam int B_CAR   = 11;
    localparam int B_CTS   = 10;
    localparam int B_RTS   = 9;
    localparam int B_SIE   = 5;
    localparam int B_MISC  = 2;
    localparam int B_TRDY  = 0;

    // event vector positions
    localparam int EV_CARLOSS = 0;
    localparam int EV_OVR     = 1;
    localparam int EV_RING    = 2;

    typedef struct packed {
        logic sie;
        logic misc;
        logic trdy;
    } ctl_t;

    typedef struct packed {
        logic [N_LEADS-1:0] level;
        logic [N_LEADS-1:0] rise;
        logic [N_LEADS-1:0] fall;
    } lead_view_t;

    function automatic ctl_t ctl_from_word(input logic [STAT_W-1:0] w);
        ctl_t c;
        c.sie  = w[B_SIE];
        c.misc = w[B_MISC];
        c.trdy = w[B_TRDY];
        return c;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [N_EVT-1:0]   flags,
        input logic [N_LEADS-1:0] live,
        input logic               rts,
        input ctl_t               c
    );
        logic [STAT_W-1:0] w;
        w           = '0;
        w[B_CARF]   = flags[EV_CARLOSS];
        w[B_OVRF]   = flags[EV_OVR];
        w[B_RINGF]  = flags[EV_RING];
        w[B_DSR]    = live[LD_DSR];
        w[B_CAR]    = live[LD_CAR];
        w[B_CTS]    = live[LD_CTS];
        w[B_RTS]    = rts;
        w[B_SIE]    = c.sie;
        w[B_MISC]   = c.misc;
        w[B_TRDY]   = c.trdy;
        return w;
    endfunction

endpackage

// File: rtl/mstat_lead_sync.sv
module mstat_lead_sync
    import mstat_pkg::*;
#(
    parameter int WIDTH  = N_LEADS,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lead_async,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] prev_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lead
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q   <= '0;
                prev_q[i] <= 1'b0;
            end else begin
                chain_q   <= {chain_q[LAST-1:0], lead_async[i]};
                prev_q[i] <= chain_q[LAST];
            end
        end

        assign level[i] = chain_q[LAST];

        // a_r2_level_shifts: the delayed copy takes the level it held one edge before
        a_r2_prev_follows: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (prev_q[i] == $past(level[i])));
    end

    always_comb begin
        rise = level & ~prev_q;
        fall = prev_q & ~level;
    end

endmodule

// File: rtl/mstat_sticky.sv
module mstat_sticky
    import mstat_pkg::*;
#(
    parameter int N = N_EVT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set[i])
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end

        assign flag[i] = flag_q;

        // R7: an event always lands, clear or not
        a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flag[i]);
        // R6: a clear with no event empties the flag
        a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
            (clr && !set[i]) |=> !flag[i]);
        // R6: without a clear the flag holds
        a_r6_sticky_hold: assert property (@(posedge clk) disable iff (rst)
            (!clr && flag[i]) |=> flag[i]);
    end

endmodule

// File: rtl/mstat_ctl.sv
module mstat_ctl
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output ctl_t              ctl
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr)
            ctl_q <= ctl_from_word(wdata);
    end

    assign ctl = ctl_q;

    // R9: unwritten control holds
    a_r9_ctl_holds: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctl));

endmodule

// File: rtl/mstat_unit.sv
module mstat_unit
    import mstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_in,
    input  logic              dsr_in,
    input  logic              cts_in,
    input  logic              ring_in,
    input  logic              overrun_evt,
    input  logic              rts_in,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] status_word,
    output logic              term_ready_o,
    output logic              misc_xmt_o,
    output logic              stat_irq_o
);
    logic [N_LEADS-1:0] leads_raw;
    lead_view_t         lv;
    logic [N_EVT-1:0]   evt_set;
    logic [N_EVT-1:0]   flags;
    logic               sw_clr;
    ctl_t               ctl;

    always_comb begin
        leads_raw          = '0;
        leads_raw[LD_CAR]  = carrier_in;
        leads_raw[LD_DSR]  = dsr_in;
        leads_raw[LD_CTS]  = cts_in;
        leads_raw[LD_RING] = ring_in;
    end

    mstat_lead_sync #(
        .WIDTH  (N_LEADS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk        (clk),
        .rst        (rst),
        .lead_async (leads_raw),
        .level      (lv.level),
        .rise       (lv.rise),
        .fall       (lv.fall)
    );

    always_comb begin
        evt_set             = '0;
        evt_set[EV_CARLOSS] = lv.fall[LD_CAR];
        evt_set[EV_OVR]     = overrun_evt;
        evt_set[EV_RING]    = lv.rise[LD_RING];
    end

    assign sw_clr = sw_wr | sw_rd;

    mstat_sticky #(.N(N_EVT)) i_flags (
        .clk  (clk),
        .rst  (rst),
        .set  (evt_set),
        .clr  (sw_clr),
        .flag (flags)
    );

    mstat_ctl i_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (sw_wr),
        .wdata (sw_wdata),
        .ctl   (ctl)
    );

    always_comb begin
        status_word  = pack_status(flags, lv.level, rts_in, ctl);
        term_ready_o = ctl.trdy;
        misc_xmt_o   = ctl.misc;
        stat_irq_o   = ctl.sie & (|flags);
    end

    // R3: a carrier drop is recorded on the next edge
    a_r3_carrier_loss: assert property (@(posedge clk) disable iff (rst)
        lv.fall[LD_CAR] |=> status_word[B_CARF]);
    // R4: a ring onset is recorded on the next edge
    a_r4_ring_onset: assert property (@(posedge clk) disable iff (rst)
        lv.rise[LD_RING] |=> status_word[B_RINGF]);
    // R5: overrun pulse lands one edge later
    a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
        overrun_evt |=> status_word[B_OVRF]);
    // R8: request stays up while nothing clears and the enable is untouched
    a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
        (stat_irq_o && !sw_wr && !sw_rd) |=> stat_irq_o);
    // R9: terminal-ready takes the written bit
    a_r9_trdy_write: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (term_ready_o == $past(sw_wdata[B_TRDY])));
    // R10: request-to-send bit mirrors its input
    a_r10_rts_live: assert property (@(posedge clk) disable iff (rst)
        status_word[B_RTS] == rts_in);

endmodule

// File: tb/test_mstat_unit.sv
module test_mstat_unit;
    import mstat_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              carrier_in = 1'b0, dsr_in = 1'b0, cts_in = 1'b0, ring_in = 1'b0;
    logic              overrun_evt = 1'b0, rts_in = 1'b0;
    logic              sw_wr = 1'b0, sw_rd = 1'b0;
    logic [15:0]       sw_wdata = '0;
    logic [15:0]       status_word;
    logic              term_ready_o, misc_xmt_o, stat_irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mstat_unit i_mstat_unit (
        .clk          (clk),
        .rst          (rst),
        .carrier_in   (carrier_in),
        .dsr_in       (dsr_in),
        .cts_in       (cts_in),
        .ring_in      (ring_in),
        .overrun_evt  (overrun_evt),
        .rts_in       (rts_in),
        .sw_wr        (sw_wr),
        .sw_rd        (sw_rd),
        .sw_wdata     (sw_wdata),
        .status_word  (status_word),
        .term_ready_o (term_ready_o),
        .misc_xmt_o   (misc_xmt_o),
        .stat_irq_o   (stat_irq_o)
    );

    // reference model state
    bit hc[$], hd[$], ht[$], hr[$];
    bit m_carf, m_ovf, m_ringf, m_tr, m_misc, m_sie;

    function automatic void hist_push(ref bit q[$], input bit v);
        q.push_back(v);
        if (q.size() > 5) void'(q.pop_front());
    endfunction

    function automatic void model_reset();
        hc = '{0,0,0,0,0}; hd = '{0,0,0,0,0};
        ht = '{0,0,0,0,0}; hr = '{0,0,0,0,0};
        m_carf = 0; m_ovf = 0; m_ringf = 0; m_tr = 0; m_misc = 0; m_sie = 0;
    endfunction

    function automatic void model_edge();
        bit s_car, s_ring, clr;
        if (rst) begin
            model_reset();
            return;
        end
        hist_push(hc, carrier_in); hist_push(hd, dsr_in);
        hist_push(ht, cts_in);     hist_push(hr, ring_in);
        s_car  = hc[1] && !hc[2];
        s_ring = !hr[1] && hr[2];
        clr    = sw_wr || sw_rd;
        m_carf  = s_car       ? 1'b1 : (clr ? 1'b0 : m_carf);
        m_ovf   = overrun_evt ? 1'b1 : (clr ? 1'b0 : m_ovf);
        m_ringf = s_ring      ? 1'b1 : (clr ? 1'b0 : m_ringf);
        if (sw_wr) begin
            m_tr = sw_wdata[0]; m_misc = sw_wdata[2]; m_sie = sw_wdata[5];
        end
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 dsr live",     int'(status_word[12]), int'(hd[3]));
        chk("R2 carrier live", int'(status_word[11]), int'(hc[3]));
        chk("R2 cts live",     int'(status_word[10]), int'(ht[3]));
        chk("R3 carrier flag", int'(status_word[15]), int'(m_carf));
        chk("R5 overrun flag", int'(status_word[14]), int'(m_ovf));
        chk("R4 ring flag",    int'(status_word[13]), int'(m_ringf));
        chk("R10 rts bit",     int'(status_word[9]),  int'(rts_in));
        chk("R10 zero bits",   int'({status_word[8:6], status_word[4:3], status_word[1]}), 0);
        chk("R9 readback",     int'({status_word[5], status_word[2], status_word[0]}),
                               int'({m_sie, m_misc, m_tr}));
        chk("R9 outputs",      int'({term_ready_o, misc_xmt_o}), int'({m_tr, m_misc}));
        chk("R8 irq",          int'(stat_irq_o), int'(m_sie && (m_carf || m_ovf || m_ringf)));
    endtask

    // one clock: model follows the edge, compare on the falling edge, then clear strobes
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        sw_wr = 1'b0; sw_rd = 1'b0; overrun_evt = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr_ctl(input logic [15:0] d);
        sw_wr = 1'b1; sw_wdata = d; tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        bit [15:0] lfsr;
        model_reset();
        @(negedge clk);
        run(3);
        // R1: reset state
        chk("R1 status after reset", int'(status_word), 0);
        chk("R1 irq after reset", int'(stat_irq_o), 0);
        rst = 1'b0;
        run(4);
        chk("R1 status idle", int'(status_word), 0);

        // carrier rises (no flag), then drops (flag, R3)
        carrier_in = 1'b1; dsr_in = 1'b1; cts_in = 1'b1;
        run(5);
        chk("R3 no flag on rise", int'(status_word[15]), 0);
        carrier_in = 1'b0;
        run(2);
        chk("R3 not yet at 2 edges", int'(status_word[15]), 0);
        run(1);
        chk("R3 set at 3 edges", int'(status_word[15]), 1);

        // enable interrupt via write, which also clears flags (R6)
        wr_ctl(16'h0025);
        chk("R6 write cleared carrier flag", int'(status_word[15]), 0);
        chk("R8 no irq without flags", int'(stat_irq_o), 0);

        // ring onset (R4) raises irq (R8)
        ring_in = 1'b1;
        run(3);
        chk("R4 ring flag", int'(status_word[13]), 1);
        chk("R8 irq with ring flag", int'(stat_irq_o), 1);
        ring_in = 1'b0;
        run(3);
        chk("R4 ring stays sticky", int'(status_word[13]), 1);

        // overrun pulse (R5), then read clears all (R6)
        overrun_evt = 1'b1; tick();
        chk("R5 overrun flag", int'(status_word[14]), 1);
        sw_rd = 1'b1; tick();
        chk("R6 read clears flags", int'(status_word[15:13]), 0);
        chk("R6 irq drops", int'(stat_irq_o), 0);

        // R7: overrun on the same edge as a read clear
        overrun_evt = 1'b1; sw_rd = 1'b1; tick();
        chk("R7 event beats clear", int'(status_word[14]), 1);

        // R9: writes to flag/live/other bits are ignored
        wr_ctl(16'hFFDA);
        chk("R9 only ctl bits stored", int'({status_word[5], status_word[2], status_word[0]}), 0);
        chk("R9 flags not set by write", int'(status_word[15:13]), 0);
        rts_in = 1'b1; @(posedge clk); model_edge(); @(negedge clk);
        chk("R10 rts live", int'(status_word[9]), 1);
        compare_all();
        wr_ctl(16'h0024);

        // pseudo-random lead activity, model compared every cycle
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:1] == 3'd0) carrier_in = ~carrier_in;
            if (lfsr[6:4] == 3'd1) ring_in    = ~ring_in;
            if (lfsr[9:7] == 3'd2) dsr_in     = ~dsr_in;
            if (lfsr[12:10] == 3'd3) cts_in   = ~cts_in;
            rts_in      = lfsr[13];
            overrun_evt = (lfsr[15:11] == 5'd7);
            sw_rd       = (lfsr[8:4] == 5'd9);
            if (lfsr[15:10] == 6'd21) begin
                sw_wr = 1'b1; sw_wdata = {lfsr[7:0], lfsr[15:8]};
            end
            tick();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule